// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the byte-wide arithmetic and logic engine of a small processor datapath. It holds an accumulator that is always one operand of every operation and, for most operations, also receives the result. The second operand is a byte that the surrounding datapath supplies on `operand`, taken from a register or an immediate field. A carry input, normally wired by the datapath from the flag byte, feeds the with-carry, with-borrow and rotate operations. After each operation a packed status byte is updated according to per-operation rules. These rules decide which of the sign, zero, half-carry, parity and carry flags are recomputed and which are left alone.

A two-state controller sequences the work. In `ST_READY`, an `exec_strobe` is accepted: the operation code, operand and carry input are captured, and the transition `ACCEPT` moves to `ST_APPLY`. In `ST_APPLY`, the computed result and flags are committed. The transition `COMMIT` always returns to `ST_READY` after one cycle, and any strobe seen during `ST_APPLY` is dropped. Instruction fetch and decode belong to the surrounding logic.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset the accumulator reads 0x00 and the flag byte reads 0x00.
- R2: The flag byte packs S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0, with bits 5, 3 and 1 always 0. When an operation recomputes them, S equals bit 7 of the result, Z is 1 when the result is 0x00, and P is 1 when the result has an even count of one bits.
- R3: Add (`op_sel`=0) and add-with-carry (`op_sel`=1) load the accumulator with acc + operand (+ `carry_in` for 1). CY is the carry out of bit 7 and AC is the carry from bit 3 into bit 4. S, Z and P are recomputed.
- R4: Subtract (`op_sel`=2) and subtract-with-borrow (`op_sel`=3) load the accumulator with acc - operand (- `carry_in` for 3), modulo 256. CY is 1 when a borrow occurs and AC is 1 when the low nibble borrows. S, Z and P are recomputed.
- R5: AND (`op_sel`=4), OR (`op_sel`=5) and XOR (`op_sel`=6) of acc with operand load the accumulator. CY and AC are cleared, and S, Z and P are recomputed.
- R6: Compare (`op_sel`=8) sets every flag exactly as subtract would, and leaves the accumulator unchanged.
- R7: Complement (`op_sel`=7) loads the accumulator with its bitwise inverse and changes no flag.
- R8: Increment (`op_sel`=9) and decrement (`op_sel`=10) load the accumulator with operand + 1 or operand - 1, modulo 256. AC is the low-nibble carry (operand low nibble 0xF) or borrow (operand low nibble 0x0). S, Z and P are recomputed and CY is unchanged.
- R9: Rotate left through carry (`op_sel`=11) gives acc = {acc[6:0], carry_in} and CY = old acc[7]. Rotate right through carry (`op_sel`=12) gives acc = {carry_in, acc[7:1]} and CY = old acc[0]. No other flag changes.
- R10: A strobe accepted at a rising edge in ST_READY shows its result after the next rising edge. A strobe present at the rising edge that commits a result is ignored.
- R11: Codes 13, 14 and 15 change neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_strobe | input | 1 | Request to perform one operation |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Second operand byte |
| carry_in | input | 1 | Carry used by with-carry, with-borrow and rotate operations |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 8 | Packed status flags |

## Verification
The bench builds the block with its default data width of 8, the only width the packed flag layout fits. At that width every nibble and byte boundary lies within a few directed operand values. These values cover a carry out of bit 7 together with a half-carry, an exact zero from subtracting equal bytes, borrows in both nibbles, and rotates that pass a one through the carry. The back-to-back strobe case checks that an operation held across the commit edge is applied only once.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int FLAG_W  = 8;
    localparam int FL_SIGN = 7;
    localparam int FL_ZERO = 6;
    localparam int FL_HALF = 4;
    localparam int FL_PAR  = 2;
    localparam int FL_CY   = 0;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CMA = 4'd7,
        OP_CMP = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_RLC = 4'd11,
        OP_RRC = 4'd12,
        OP_NA0 = 4'd13,
        OP_NA1 = 4'd14,
        OP_NA2 = 4'd15
    } alu_op_t;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_APPLY = 1'b1
    } alu_state_t;
endpackage

// File: rtl/acc_alu_seq.sv
module acc_alu_seq
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_strobe,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] operand,
    input  logic          carry_in,
    output alu_op_t       op_q,
    output logic [DW-1:0] opd_q,
    output logic          cin_q,
    output logic          commit
);
    alu_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: if (exec_strobe) state_nx = ST_APPLY; // ACCEPT
            ST_APPLY: state_nx = ST_READY;                   // COMMIT
            default:  state_nx = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NA0;
            opd_q <= '0;
            cin_q <= 1'b0;
        end else if (state == ST_READY && exec_strobe) begin
            op_q  <= alu_op_t'(op_sel);
            opd_q <= operand;
            cin_q <= carry_in;
        end
    end

    assign commit = (state == ST_APPLY);

    p_apply_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_APPLY) |=> (state == ST_READY));
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_t           op,
    input  logic [DW-1:0]     acc,
    input  logic [DW-1:0]     opd,
    input  logic              cin,
    input  logic [FLAG_W-1:0] fl_in,
    output logic [DW-1:0]     res,
    output logic              wr_acc,
    output logic [FLAG_W-1:0] fl_out
);
    localparam int H = DW / 2;

    logic [DW:0]  wide;
    logic [H:0]   nib;
    logic [DW-1:0] tmp;
    logic         cbit;

    function automatic logic [FLAG_W-1:0] pack(input logic [DW-1:0] r,
                                               input logic hc, input logic cy);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[FL_SIGN] = r[DW-1];
        f[FL_ZERO] = (r == '0);
        f[FL_HALF] = hc;
        f[FL_PAR]  = ~^r;
        f[FL_CY]   = cy;
        return f;
    endfunction

    always_comb begin
        res    = acc;
        wr_acc = 1'b0;
        fl_out = fl_in;
        wide   = '0;
        nib    = '0;
        tmp    = '0;
        cbit   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                cbit   = (op == OP_ADC) ? cin : 1'b0;
                wide   = {1'b0, acc} + {1'b0, opd} + {{DW{1'b0}}, cbit};
                nib    = {1'b0, acc[H-1:0]} + {1'b0, opd[H-1:0]} + {{H{1'b0}}, cbit};
                res    = wide[DW-1:0];
                wr_acc = 1'b1;
                fl_out = pack(wide[DW-1:0], nib[H], wide[DW]);
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                cbit   = (op == OP_SBB) ? cin : 1'b0;
                wide   = {1'b0, acc} - {1'b0, opd} - {{DW{1'b0}}, cbit};
                nib    = {1'b0, acc[H-1:0]} - {1'b0, opd[H-1:0]} - {{H{1'b0}}, cbit};
                res    = (op == OP_CMP) ? acc : wide[DW-1:0];
                wr_acc = (op != OP_CMP);
                fl_out = pack(wide[DW-1:0], nib[H], wide[DW]);
            end
            OP_AND, OP_OR, OP_XOR: begin
                tmp    = (op == OP_AND) ? (acc & opd) :
                         (op == OP_OR)  ? (acc | opd) : (acc ^ opd);
                res    = tmp;
                wr_acc = 1'b1;
                fl_out = pack(tmp, 1'b0, 1'b0);
            end
            OP_CMA: begin
                res    = ~acc;
                wr_acc = 1'b1;
            end
            OP_INC, OP_DEC: begin
                tmp    = (op == OP_INC) ? (opd + 1'b1) : (opd - 1'b1);
                cbit   = (op == OP_INC) ? (opd[H-1:0] == {H{1'b1}})
                                        : (opd[H-1:0] == {H{1'b0}});
                res    = tmp;
                wr_acc = 1'b1;
                fl_out = pack(tmp, cbit, fl_in[FL_CY]);
            end
            OP_RLC: begin
                res    = {acc[DW-2:0], cin};
                wr_acc = 1'b1;
                fl_out[FL_CY] = acc[DW-1];
            end
            OP_RRC: begin
                res    = {cin, acc[DW-1:1]};
                wr_acc = 1'b1;
                fl_out[FL_CY] = acc[0];
            end
            default: begin
                res    = acc;
                wr_acc = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_strobe,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] operand,
    input  logic          carry_in,
    output logic [DW-1:0] acc_out,
    output logic [7:0]    flags_out
);
    alu_op_t           op_q;
    logic [DW-1:0]     opd_q;
    logic              cin_q;
    logic              commit;
    logic [DW-1:0]     acc_q;
    logic [FLAG_W-1:0] flag_q;
    logic [DW-1:0]     res;
    logic              wr_acc;
    logic [FLAG_W-1:0] fl_nx;

    acc_alu_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .exec_strobe(exec_strobe),
        .op_sel(op_sel), .operand(operand), .carry_in(carry_in),
        .op_q(op_q), .opd_q(opd_q), .cin_q(cin_q), .commit(commit)
    );

    acc_alu_core #(.DW(DW)) u_core (
        .op(op_q), .acc(acc_q), .opd(opd_q), .cin(cin_q), .fl_in(flag_q),
        .res(res), .wr_acc(wr_acc), .fl_out(fl_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_q <= '0;
        end else if (commit) begin
            if (wr_acc) acc_q <= res;
            flag_q <= fl_nx;
        end
    end

    assign acc_out   = acc_q;
    assign flags_out = flag_q;

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[5] == 1'b0 && flag_q[3] == 1'b0 && flag_q[1] == 1'b0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(acc_q) && $stable(flag_q)));

    p_cmp_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_CMP) |=> $stable(acc_q));

    p_logic_clears_cy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR))
        |=> (!flag_q[FL_CY] && !flag_q[FL_HALF]));

    p_cma_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_CMA) |=> $stable(flag_q));

    p_incdec_keeps_cy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (op_q == OP_INC || op_q == OP_DEC)) |=> $stable(flag_q[FL_CY]));
endmodule

// File: tb/sim_acc_alu_unit.sv
`timescale 1ns/1ps
module sim_acc_alu_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_strobe = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] operand = '0;
    logic       carry_in = 1'b0;
    logic [7:0] acc_out;
    logic [7:0] flags_out;

    int total = 0;
    int bad = 0;
    logic [7:0] m_acc = '0;
    logic [7:0] m_fl = '0;
    bit done = 0;

    acc_alu_unit u0 (
        .clk(clk), .rst_n(rst_n), .exec_strobe(exec_strobe), .op_sel(op_sel),
        .operand(operand), .carry_in(carry_in), .acc_out(acc_out), .flags_out(flags_out)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] mk_fl(input logic [7:0] r, input logic hc, input logic cy);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += r[i];
        return {r[7], (r == 8'h00), 1'b0, hc, 1'b0, (ones % 2 == 0), 1'b0, cy};
    endfunction

    task automatic model(input logic [3:0] o, input logic [7:0] b, input logic c);
        int a = m_acc, bb = b, ci, s;
        case (o)
            4'd0, 4'd1: begin
                ci = (o == 4'd1) ? c : 0;
                s = a + bb + ci;
                m_fl = mk_fl(s[7:0], ((a % 16) + (bb % 16) + ci) > 15, s > 255);
                m_acc = s[7:0];
            end
            4'd2, 4'd3, 4'd8: begin
                ci = (o == 4'd3) ? c : 0;
                s = a - bb - ci;
                m_fl = mk_fl(s[7:0], (a % 16) < (bb % 16) + ci, s < 0);
                if (o != 4'd8) m_acc = s[7:0];
            end
            4'd4: begin m_acc = m_acc & b; m_fl = mk_fl(m_acc, 0, 0); end
            4'd5: begin m_acc = m_acc | b; m_fl = mk_fl(m_acc, 0, 0); end
            4'd6: begin m_acc = m_acc ^ b; m_fl = mk_fl(m_acc, 0, 0); end
            4'd7: m_acc = 8'hFF - m_acc;
            4'd9: begin s = (bb + 1) % 256; m_fl = mk_fl(s[7:0], (bb % 16) == 15, m_fl[0]); m_acc = s[7:0]; end
            4'd10: begin s = (bb + 255) % 256; m_fl = mk_fl(s[7:0], (bb % 16) == 0, m_fl[0]); m_acc = s[7:0]; end
            4'd11: begin m_fl[0] = m_acc[7]; m_acc = {m_acc[6:0], c}; end
            4'd12: begin m_fl[0] = m_acc[0]; m_acc = {c, m_acc[7:1]}; end
            default: ;
        endcase
    endtask

    task automatic check(input string req);
        total++;
        if (acc_out !== m_acc || flags_out !== m_fl) begin
            bad++;
            $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h",
                     req, acc_out, flags_out, m_acc, m_fl);
        end
    endtask

    task automatic do_op(input logic [3:0] o, input logic [7:0] b, input logic c);
        @(negedge clk);
        exec_strobe = 1'b1; op_sel = o; operand = b; carry_in = c;
        @(posedge clk);
        @(negedge clk);
        exec_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model(o, b, c);
    endtask

    task automatic set_acc(input logic [7:0] v);
        do_op(4'd4, 8'h00, 1'b0);
        do_op(4'd5, v, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset");
    endtask

    task automatic t_add;
        set_acc(8'hF1); do_op(4'd0, 8'h1F, 1'b0); check("R3 add F1+1F carry and AC");
        set_acc(8'h1F); do_op(4'd0, 8'h11, 1'b0); check("R3 add 1F+11 AC");
        set_acc(8'h7F); do_op(4'd1, 8'h00, 1'b1); check("R3 adc with carry_in sign");
        set_acc(8'hFF); do_op(4'd1, 8'h00, 1'b1); check("R2 zero flag from adc");
    endtask

    task automatic t_sub;
        set_acc(8'hFF); do_op(4'd2, 8'hFF, 1'b0); check("R4 sub FF-FF zero");
        set_acc(8'h07); do_op(4'd2, 8'h08, 1'b0); check("R4 sub 7-8 borrow sign");
        set_acc(8'h20); do_op(4'd3, 8'h10, 1'b1); check("R4 sbb nibble borrow");
        set_acc(8'h0A); do_op(4'd2, 8'h02, 1'b0); check("R2 parity of 08");
    endtask

    task automatic t_logic;
        set_acc(8'hFF); do_op(4'd0, 8'h01, 1'b0);
        do_op(4'd5, 8'h3C, 1'b0); check("R5 or clears CY");
        do_op(4'd4, 8'h0F, 1'b0); check("R5 and");
        do_op(4'd6, 8'h8F, 1'b0); check("R5 xor sign");
    endtask

    task automatic t_cmp;
        set_acc(8'h10); do_op(4'd8, 8'h20, 1'b0); check("R6 cmp less keeps acc");
        do_op(4'd8, 8'h10, 1'b0); check("R6 cmp equal");
    endtask

    task automatic t_cma;
        set_acc(8'h07); do_op(4'd2, 8'h08, 1'b0);
        do_op(4'd7, 8'h00, 1'b0); check("R7 complement keeps flags");
    endtask

    task automatic t_incdec;
        set_acc(8'hFF); do_op(4'd0, 8'h01, 1'b0);
        do_op(4'd9, 8'hFF, 1'b0); check("R8 inc FF keeps CY");
        do_op(4'd10, 8'h10, 1'b0); check("R8 dec 10 nibble borrow");
        set_acc(8'h00);
        do_op(4'd10, 8'h00, 1'b0); check("R8 dec 00 CY unchanged");
    endtask

    task automatic t_rotate;
        set_acc(8'h81);
        do_op(4'd11, 8'h00, 1'b0); check("R9 rotate left carry out");
        do_op(4'd12, 8'h00, 1'b1); check("R9 rotate right carry in");
        do_op(4'd12, 8'h00, 1'b0); check("R9 rotate right second");
    endtask

    task automatic t_overlap;
        set_acc(8'h05);
        @(negedge clk);
        exec_strobe = 1'b1; op_sel = 4'd0; operand = 8'h03; carry_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        exec_strobe = 1'b0;
        model(4'd0, 8'h03, 1'b0);
        check("R10 strobe at commit edge ignored");
        @(posedge clk);
        @(negedge clk);
        check("R10 no late second apply");
    endtask

    task automatic t_unused;
        set_acc(8'h5A); do_op(4'd2, 8'h5B, 1'b0);
        do_op(4'd13, 8'hFF, 1'b1); check("R11 code 13 no effect");
        do_op(4'd15, 8'h01, 1'b1); check("R11 code 15 no effect");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_cmp();
        t_cma();
        t_incdec();
        t_rotate();
        t_overlap();
        t_unused();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule